// File: doc/BRIEF.md
# Partition Header Sealer

This block completes the 16-byte header of a partition held in a byte-wide non-volatile memory image. A host first writes the signature, the name and the payload into the memory. It then pulses `start` with the partition's first address and its end address. The sealer rounds the span up to a whole number of 16-byte units and writes that unit count into the two length bytes of the header. It then reads the header back, one byte at a time, and folds the bytes into an 8-bit end-around-carry checksum. It writes the checksum into the header's check byte and pulses `done`.

The header layout is fixed. The signature byte is at offset 0, the check byte at offset 1, the length (high byte first) at offsets 2 and 3, and the 12-character name at offsets 4 to 15. The block drives a plain synchronous single-port byte RAM: one address, a write enable, write data, and read data that appears one cycle after its address. Control is a start pulse in and busy/done levels out. There is no streaming edge, so no valid/ready handshake applies: the block alone owns the RAM port while busy, and the RAM never stalls it. The block does not check the addresses against the memory size; addresses wrap modulo 2^AW.

Top module: `part_hdr_sealer`

## Requirements
- R1: `start` is taken only while `busy` is low. `busy` is high in the cycle after the sampling edge. A `start` pulse while `busy` is high has no effect on the memory, the addresses in use, or the number of `done` pulses.
- R2: With span = (end − start) mod 2^AW rounded up to a multiple of 16, the byte written at start+2 is span bits 19:12 and the byte written at start+3 is span bits 11:4. Together they are the length in 16-byte units, high byte first.
- R3: Both length bytes are written, start+2 first and then start+3, before any header read is issued, so the checksum covers the new length.
- R4: The checksum is loaded with the byte at start+0. It then takes the bytes at start+2 through start+15, in increasing address order. The byte at start+1 never enters the sum.
- R5: Each addition forms a 9-bit sum, adds its bit 8 back into the low byte, and keeps 8 bits.
- R6: The final checksum is written to start+1 as the third and last write of the run.
- R7: `done` is high for exactly one cycle. It rises 33 rising edges after the edge that samples `start`, and `busy` is low in the following cycle.
- R8: Each read address is held for two cycles, and its data is used only in the second cycle (one-cycle read latency). A run makes exactly three writes, so header bytes 0 and 4..15 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run; sampled only while idle |
| start_addr | input | AW | First byte of the partition (header offset 0) |
| end_addr | input | AW | Address one past the partition payload |
| busy | output | 1 | High from the cycle after acceptance until the done cycle inclusive |
| done | output | 1 | One-cycle pulse after the checksum write |
| mem_addr | output | AW | RAM byte address |
| mem_we | output | 1 | RAM write enable |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, valid one cycle after its address |

## Verification
Counting from the edge that samples `start`, the high length byte is written in cycle 1 and the low length byte in cycle 2. Header reads then fill cycles 3 to 32 in issue/wait pairs, the checksum write falls in cycle 33, and `done` is high right after edge 33. The bench stamps the accepting edge with a free-running cycle counter. A monitor samples on falling edges, logs every write address in order, and on each `done` pops the scoreboard entry and compares the elapsed count against 33. After that it compares all sixteen header bytes of the bench RAM against the image the driver predicted. Ignored `start` pulses are judged by an untouched decoy header and by the absence of any extra `done`.

// File: rtl/phs_pkg.sv
package phs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR_HI,
    S_WR_LO,
    S_RD_ISSUE,
    S_RD_WAIT,
    S_WR_CK,
    S_DONE
  } seq_state_t;

  typedef enum logic [1:0] {
    W_LEN_HI,
    W_LEN_LO,
    W_CHECK
  } wsel_t;

  localparam int unsigned HDR_BYTES  = 16;
  localparam int unsigned SUM_READS  = HDR_BYTES - 1;  // every byte except the check byte
  localparam int unsigned OFS_CHECK  = 1;
  localparam int unsigned OFS_LEN_HI = 2;
  localparam int unsigned OFS_LEN_LO = 3;
  localparam int unsigned UNIT_SHIFT = 4;              // 16-byte units
  localparam int unsigned LEN_FIELD  = 16;             // two length bytes

  // 8-bit add with end-around carry (R5)
  function automatic logic [7:0] fold_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

endpackage

// File: rtl/phs_len_calc.sv
module phs_len_calc #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] base_in,
  input  logic [AW-1:0] limit_in,
  output logic [7:0]    units_hi,
  output logic [7:0]    units_lo
);
  import phs_pkg::*;

  localparam int TOP_BIT = UNIT_SHIFT + LEN_FIELD;           // 20
  localparam int DW      = ((AW > TOP_BIT) ? AW : TOP_BIT) + 1;
  localparam int RND     = (1 << UNIT_SHIFT) - 1;

  logic [AW-1:0] diff;
  logic [DW-1:0] span;
  logic [DW-1:0] rounded;

  // R2: round the span up to whole units, then split the unit count
  always_comb begin
    diff     = limit_in - base_in;
    span     = DW'(diff);
    rounded  = (span + DW'(RND)) & ~DW'(RND);
    units_hi = rounded[UNIT_SHIFT+15:UNIT_SHIFT+8];
    units_lo = rounded[UNIT_SHIFT+7:UNIT_SHIFT];
  end

endmodule

// File: rtl/phs_fold_acc.sv
module phs_fold_acc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic       add,
  input  logic [7:0] din,
  output logic [7:0] sum
);
  import phs_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sum <= 8'd0;
    else if (load) sum <= din;                 // R4: seed with signature byte
    else if (add)  sum <= fold_add(sum, din);  // R5
  end

  AST_LOAD_ADD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && add)); // R4

endmodule

// File: rtl/phs_seq.sv
module phs_seq (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  output logic               accept,
  output logic               busy,
  output logic               done,
  output logic               mem_we,
  output phs_pkg::wsel_t     wsel,
  output logic [3:0]         ofs,
  output logic               acc_load,
  output logic               acc_add
);
  import phs_pkg::*;

  localparam int CW = $clog2(SUM_READS + 1);

  seq_state_t    state;
  logic [CW-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rd_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (go) begin
          state  <= S_WR_HI;
          rd_cnt <= '0;
        end
        S_WR_HI:    state <= S_WR_LO;
        S_WR_LO:    state <= S_RD_ISSUE;   // R3: both length writes precede reads
        S_RD_ISSUE: state <= S_RD_WAIT;    // R8: wait one cycle for data
        S_RD_WAIT: begin
          rd_cnt <= rd_cnt + 1'b1;
          state  <= (rd_cnt == CW'(SUM_READS - 1)) ? S_WR_CK : S_RD_ISSUE;
        end
        S_WR_CK:    state <= S_DONE;
        S_DONE:     state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    accept   = (state == S_IDLE) && go;   // R1
    busy     = (state != S_IDLE);
    done     = (state == S_DONE);
    mem_we   = 1'b0;
    wsel     = W_CHECK;
    ofs      = 4'd0;
    acc_load = 1'b0;
    acc_add  = 1'b0;
    case (state)
      S_WR_HI: begin mem_we = 1'b1; wsel = W_LEN_HI; ofs = 4'(OFS_LEN_HI); end
      S_WR_LO: begin mem_we = 1'b1; wsel = W_LEN_LO; ofs = 4'(OFS_LEN_LO); end
      S_RD_ISSUE, S_RD_WAIT: begin
        // R4: offset 0 first, then 2..15, skipping the check byte
        ofs = (rd_cnt == '0) ? 4'd0 : 4'(rd_cnt + 1'b1);
        if (state == S_RD_WAIT) begin
          acc_load = (rd_cnt == '0);
          acc_add  = (rd_cnt != '0);
        end
      end
      S_WR_CK: begin mem_we = 1'b1; wsel = W_CHECK; ofs = 4'(OFS_CHECK); end
      default: ;
    endcase
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R8
  AST_WAIT_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RD_WAIT) |-> ($past(state) == S_RD_ISSUE)); // R8
  AST_CK_AFTER_ALL_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WR_CK) |-> (rd_cnt == CW'(SUM_READS))); // R4
  AST_DONE_AFTER_CK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_we)); // R6

endmodule

// File: rtl/part_hdr_sealer.sv
module part_hdr_sealer #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [AW-1:0] end_addr,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  import phs_pkg::*;

  logic          accept;
  logic [7:0]    calc_hi, calc_lo;
  logic [AW-1:0] base_q;
  logic [7:0]    hi_q, lo_q;
  wsel_t         wsel;
  logic [3:0]    ofs;
  logic          acc_load, acc_add;
  logic [7:0]    ck_sum;

  phs_len_calc #(.AW(AW)) u_len (
    .base_in  (start_addr),
    .limit_in (end_addr),
    .units_hi (calc_hi),
    .units_lo (calc_lo)
  );

  phs_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (start),
    .accept   (accept),
    .busy     (busy),
    .done     (done),
    .mem_we   (mem_we),
    .wsel     (wsel),
    .ofs      (ofs),
    .acc_load (acc_load),
    .acc_add  (acc_add)
  );

  phs_fold_acc u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (acc_load),
    .add   (acc_add),
    .din   (mem_rdata),
    .sum   (ck_sum)
  );

  // R1: capture the job only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      hi_q   <= 8'd0;
      lo_q   <= 8'd0;
    end else if (accept) begin
      base_q <= start_addr;
      hi_q   <= calc_hi;
      lo_q   <= calc_lo;
    end
  end

  always_comb begin
    mem_addr = base_q + AW'(ofs);
    case (wsel)
      W_LEN_HI: mem_wdata = hi_q;   // R2
      W_LEN_LO: mem_wdata = lo_q;   // R2
      default:  mem_wdata = ck_sum; // R6
    endcase
  end

  AST_JOB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(base_q) && $stable(hi_q) && $stable(lo_q))); // R1

endmodule

// File: tb/part_hdr_sealer_test.sv
`timescale 1ns/1ps
module part_hdr_sealer_test;
  localparam int AW = 16;
  localparam int LATENCY = 33;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [AW-1:0] end_addr = '0;
  logic          busy, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata;

  always #2.5 clk = ~clk;

  part_hdr_sealer #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .end_addr(end_addr), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // bench RAM, 4 KiB aliased image
  logic [7:0] ram [0:4095];
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[11:0]];
  end

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int done_cnt = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int               base;
    int               t0;
    logic [15:0][7:0] img;
  } exp_t;
  exp_t sb[$];
  int   wr_log[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_fold(input logic [7:0] a, input logic [7:0] b);
    int t;
    t = int'(a) + int'(b);
    if (t > 255) t = t - 256 + 1;
    return t[7:0];
  endfunction

  // monitor: compares each finished run against the scoreboard
  logic prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) wr_log.push_back(int'(mem_addr));
      if (done) begin
        done_cnt++;
        chk(!prev_done, "R7 done width", 1, 0);
        if (sb.size() == 0) begin
          chk(1'b0, "R1 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(cyc - e.t0 == LATENCY, "R7 done latency", cyc - e.t0, LATENCY);
          chk(wr_log.size() == 3, "R8 write count", wr_log.size(), 3);
          if (wr_log.size() == 3) begin
            chk(wr_log[0] == e.base + 2, "R3 first write addr", wr_log[0], e.base + 2);
            chk(wr_log[1] == e.base + 3, "R3 second write addr", wr_log[1], e.base + 3);
            chk(wr_log[2] == e.base + 1, "R6 last write addr", wr_log[2], e.base + 1);
          end
          for (int k = 0; k < 16; k++) begin
            logic [7:0] got;
            got = ram[(e.base + k) & 12'hFFF];
            if (k == 1)
              chk(got == e.img[k], "R4 R5 R6 checksum", got, e.img[k]);
            else if (k == 2 || k == 3)
              chk(got == e.img[k], "R2 length byte", got, e.img[k]);
            else
              chk(got == e.img[k], "R8 header byte untouched", got, e.img[k]);
          end
        end
        wr_log.delete();
      end
      prev_done <= done;
    end
  end

  // driver: preload header, predict, launch
  task automatic run(input int s, input int e, input int seed, input bit all_ff,
                     input int decoy);
    exp_t x;
    logic [15:0] diff;
    int rounded, ck, n0;
    for (int k = 0; k < 16; k++) begin
      logic [7:0] b;
      b = all_ff ? 8'hFF : 8'((seed * 37) ^ (k * 29 + 7));
      ram[(s + k) & 12'hFFF] = b;
      x.img[k] = b;
    end
    diff    = 16'(e - s);
    rounded = (int'(diff) + 15) & ~15;
    x.img[2] = 8'(rounded >> 12);
    x.img[3] = 8'(rounded >> 4);
    ck = x.img[0];
    for (int k = 2; k < 16; k++) ck = ref_fold(8'(ck), x.img[k]);
    x.img[1] = 8'(ck);
    x.base = s;
    n0 = done_cnt;
    @(negedge clk);
    start_addr = AW'(s);
    end_addr   = AW'(e);
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    x.t0 = cyc;
    sb.push_back(x);
    chk(busy == 1'b1, "R1 busy after accept", busy, 1);
    if (decoy >= 0) begin
      repeat (5) @(negedge clk);
      start_addr = AW'(decoy);
      end_addr   = AW'(decoy + 16'h0400);
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int w = 0; w < 200 && done_cnt == n0; w++) @(negedge clk);
    chk(done_cnt == n0 + 1, "R7 done arrived", done_cnt - n0, 1);
    @(negedge clk);
    chk(busy == 1'b0, "R7 idle after done", busy, 0);
    chk(done == 1'b0, "R7 done dropped", done, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int a = 0; a < 4096; a++) ram[a] = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1 reset busy", busy, 0);
    chk(done == 1'b0, "R7 reset done", done, 0);
    chk(mem_we == 1'b0, "R8 reset write enable", mem_we, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run(16'h0040, 16'h00A0, 3, 1'b0, -1);  // R2 exact multiple
    run(16'h0100, 16'h0137, 5, 1'b0, -1);  // R2 rounding up
    run(16'h0200, 16'h0200, 9, 1'b0, -1);  // R2 zero length
    run(16'h0010, 16'hFFF5, 0, 1'b1, -1);  // R2 R5 high byte, heavy carries
    run(16'h03F0, 16'h1625, 11, 1'b0, -1); // R2 both bytes nonzero

    // R1: start during busy is ignored; decoy header must stay intact
    for (int k = 0; k < 16; k++) ram[16'h0800 + k] = 8'(8'hA0 + k);
    run(16'h0300, 16'h1000, 17, 1'b0, 16'h0800);
    for (int k = 1; k < 4; k++)
      chk(ram[16'h0800 + k] == 8'(8'hA0 + k), "R1 decoy untouched",
          ram[16'h0800 + k], 8'hA0 + k);
    repeat (40) @(negedge clk);
    chk(done_cnt == 6, "R1 no extra done", done_cnt, 6);
    chk(sb.size() == 0, "R1 scoreboard drained", sb.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule